// File: doc/BRIEF.md
# Core-Local Timer and Software Interrupt Unit

This block sits beside a single processor core and produces two interrupt lines for it. The first line comes from a free-running time counter that steps by one on every clock. The second comes from a one-bit software flag. The counter is compared against a compare register that software loads. While the counter is at or past the compare value, the timer line is held high.

There is no bus. Software loads the compare register and the software flag through dedicated write-enable and data ports. The running counter value is driven out on its own port at all times, so other logic can read it. Software cannot write the counter. The counter and compare width is a parameter, 64 bits by default.

Reset is synchronous and active-high. It returns the counter, the compare register, the software flag and both interrupt lines to zero. Both interrupt lines come straight from flip-flops.

Top module: `core_timer_irq`

## Requirements
- R1: While `rst` is low, `count_o` increases by exactly one at every rising clock edge.
- R2: A rising edge with `cmp_we` high loads `cmp_wdata` into the compare register. The compare register holds its value at every other edge.
- R3: After each edge without reset, `timer_irq_o` equals the unsigned test (value of `count_o` just before the edge) >= (compare value just after the edge). If the compare register is written at that edge, the newly written value is used.
- R4: Reset leaves the compare register at zero. The first edge after reset is released therefore raises `timer_irq_o`, unless a nonzero compare value is written at that same edge.
- R5: Once `timer_irq_o` is high, it stays high until a compare value greater than the counter is written. Writing a value equal to or below the counter leaves it high.
- R6: An edge with `sw_we` high loads `sw_wdata` into the software flag (1 sets it, 0 clears it). `soft_irq_o` shows the flag, and it holds its value at every edge with `sw_we` low.
- R7: An edge with `rst` high clears `count_o`, the compare register, `soft_irq_o` and `timer_irq_o` to zero. Reset takes priority over any write made at that edge.
- R8: The counter wraps from all ones to zero and raises no flag. After the wrap, the comparison is evaluated again, so a held timer interrupt drops one edge later if the compare value is above zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_we | input | 1 | Load strobe for the compare register |
| cmp_wdata | input | TIME_W | New compare value |
| sw_we | input | 1 | Load strobe for the software flag |
| sw_wdata | input | 1 | New software flag value |
| count_o | output | TIME_W | Current time counter |
| timer_irq_o | output | 1 | Timer interrupt, registered |
| soft_irq_o | output | 1 | Software interrupt, registered |

## Verification
The bench targets the edge where the compare value equals the counter. A design that uses a strict greater-than comparison would raise the timer line one cycle late, and a design that compares against the old compare value would glitch when the compare register is written. It writes compare values equal to the counter and below it while the interrupt is held, which catches a design that clears on any write. It uses a second instance with an 8-bit counter to reach the wrap, where a design with a sticky interrupt would fail to drop the line. It also asserts reset while writes are pending, which catches a design that lets a write override reset.

// File: rtl/ctimer_pkg.sv
package ctimer_pkg;

  // One-bit register load request: strobe plus value.
  typedef struct packed {
    logic en;
    logic val;
  } bit_wr_t;

  // Unsigned "at or past" test used by the compare stage.
  function automatic logic at_or_past(input logic [127:0] now_v,
                                      input logic [127:0] limit_v);
    return now_v >= limit_v;
  endfunction

endpackage

// File: rtl/ctimer_counter.sv
module ctimer_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] cnt_o
);

  localparam logic [W-1:0] STEP = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_q + STEP;
  end

  assign cnt_o = cnt_q;

  // R1: one step per edge, wrapping naturally (R8)
  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (cnt_q == $past(cnt_q) + STEP));

endmodule

// File: rtl/ctimer_compare.sv
module ctimer_compare
  import ctimer_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] cnt_i,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic         irq_o
);

  localparam int PADW = 128 - W;

  logic [W-1:0] cmp_q;
  logic [W-1:0] cmp_next;
  logic         hit;
  logic         irq_q;

  // The value the register will hold after this edge is used for the test.
  always_comb begin
    cmp_next = wr_en ? wr_data : cmp_q;
    hit      = at_or_past({{PADW{1'b0}}, cnt_i}, {{PADW{1'b0}}, cmp_next});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cmp_q <= cmp_next;
      irq_q <= hit;
    end
  end

  assign irq_o = irq_q;

  // R3: without a write, the line follows last counter against held compare
  a_r3_irq_eval: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> (irq_q == ($past(cnt_i) >= cmp_q)));

  // R5: a held line survives any cycle without a write unless the counter wrapped
  a_r5_irq_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !wr_en && (cnt_i != '0)) |=> irq_q);

  // R2: compare register keeps its value when not written
  a_r2_cmp_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr_en) |=> $stable(cmp_q));

endmodule

// File: rtl/ctimer_swflag.sv
module ctimer_swflag
  import ctimer_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  bit_wr_t wr,
  output logic    flag_o
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst)         flag_q <= 1'b0;
    else if (wr.en)  flag_q <= wr.val;
  end

  assign flag_o = flag_q;

  // R6: a load takes the written bit
  a_r6_flag_load: assert property (@(posedge clk) disable iff (rst)
    (wr.en) |=> (flag_q == $past(wr.val)));

  // R6: no load, no change
  a_r6_flag_hold: assert property (@(posedge clk) disable iff (rst)
    (!wr.en) |=> $stable(flag_q));

endmodule

// File: rtl/core_timer_irq.sv
module core_timer_irq
  import ctimer_pkg::*;
#(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_we,
  input  logic [TIME_W-1:0] cmp_wdata,
  input  logic              sw_we,
  input  logic              sw_wdata,
  output logic [TIME_W-1:0] count_o,
  output logic              timer_irq_o,
  output logic              soft_irq_o
);

  logic [TIME_W-1:0] cnt;
  bit_wr_t           sw_req;

  assign sw_req = '{en: sw_we, val: sw_wdata};

  ctimer_counter #(.W(TIME_W)) u_counter (
    .clk   (clk),
    .rst   (rst),
    .cnt_o (cnt)
  );

  ctimer_compare #(.W(TIME_W)) u_compare (
    .clk     (clk),
    .rst     (rst),
    .cnt_i   (cnt),
    .wr_en   (cmp_we),
    .wr_data (cmp_wdata),
    .irq_o   (timer_irq_o)
  );

  ctimer_swflag u_swflag (
    .clk    (clk),
    .rst    (rst),
    .wr     (sw_req),
    .flag_o (soft_irq_o)
  );

  assign count_o = cnt;

endmodule

// File: tb/core_timer_irq_tb.sv
module core_timer_irq_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmp_we = 1'b0;
  logic [63:0] cmp_wdata = '0;
  logic sw_we = 1'b0;
  logic sw_wdata = 1'b0;
  logic cmp8_we = 1'b0;
  logic [7:0] cmp8_wdata = '0;

  logic [63:0] count_o;
  logic timer_irq_o, soft_irq_o;
  logic [7:0] count8;
  logic irq8, soft8;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench-side expectations
  logic [63:0] m_cnt = '0;
  logic [63:0] m_cmp = '0;
  logic [7:0]  m_cmp8 = '0;
  logic        m_irq = 1'b0, m_irq8 = 1'b0, m_soft = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  core_timer_irq #(.TIME_W(64)) u_dut (
    .clk(clk), .rst(rst), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
    .sw_we(sw_we), .sw_wdata(sw_wdata),
    .count_o(count_o), .timer_irq_o(timer_irq_o), .soft_irq_o(soft_irq_o));

  core_timer_irq #(.TIME_W(8)) u_dut_w (
    .clk(clk), .rst(rst), .cmp_we(cmp8_we), .cmp_wdata(cmp8_wdata),
    .sw_we(sw_we), .sw_wdata(sw_wdata),
    .count_o(count8), .timer_irq_o(irq8), .soft_irq_o(soft8));

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  // One clock: inputs are already driven at a falling edge.
  task automatic step();
    logic [63:0] ncmp;
    logic [7:0]  ncmp8;
    @(posedge clk);
    if (rst) begin
      m_cnt = '0; m_cmp = '0; m_cmp8 = '0;
      m_irq = 1'b0; m_irq8 = 1'b0; m_soft = 1'b0;
    end else begin
      ncmp  = cmp_we  ? cmp_wdata  : m_cmp;
      ncmp8 = cmp8_we ? cmp8_wdata : m_cmp8;
      m_irq  = (m_cnt >= ncmp);
      m_irq8 = (m_cnt[7:0] >= ncmp8);
      m_cmp  = ncmp;
      m_cmp8 = ncmp8;
      if (sw_we) m_soft = sw_wdata;
      m_cnt = m_cnt + 64'd1;
    end
    @(negedge clk);
    cmp_we = 1'b0; sw_we = 1'b0; cmp8_we = 1'b0;
    check("R1 count", count_o, m_cnt);
    check("R3 timer_irq", {63'd0, timer_irq_o}, {63'd0, m_irq});
    check("R6 soft_irq", {63'd0, soft_irq_o}, {63'd0, m_soft});
    check("R8 narrow count", {56'd0, count8}, {56'd0, m_cnt[7:0]});
    check("R8 narrow irq", {63'd0, irq8}, {63'd0, m_irq8});
  endtask

  task automatic test_reset();
    rst = 1'b1;
    sw_we = 1'b1; sw_wdata = 1'b1;
    cmp_we = 1'b1; cmp_wdata = 64'd5;
    step();
    repeat (2) step();
    check("R7 count zero in reset", count_o, 64'd0);
    check("R7 timer_irq zero in reset", {63'd0, timer_irq_o}, 64'd0);
    check("R7 soft_irq zero, write ignored", {63'd0, soft_irq_o}, 64'd0);
  endtask

  task automatic test_first_irq();
    rst = 1'b0;
    step();
    check("R4 timer_irq after release", {63'd0, timer_irq_o}, 64'd1);
    check("R1 count after release", count_o, 64'd1);
    step();
    check("R1 count second edge", count_o, 64'd2);
  endtask

  task automatic test_future_compare();
    logic [63:0] target;
    target = m_cnt + 64'd6;
    cmp_we = 1'b1; cmp_wdata = target;
    step();
    check("R2 future compare drops irq", {63'd0, timer_irq_o}, 64'd0);
    while (m_cnt <= target) step();
    check("R3 irq raised once count reached compare", {63'd0, timer_irq_o}, 64'd1);
  endtask

  task automatic test_not_larger();
    cmp_we = 1'b1; cmp_wdata = m_cnt;
    step();
    check("R5 equal write keeps irq", {63'd0, timer_irq_o}, 64'd1);
    cmp_we = 1'b1; cmp_wdata = m_cnt - 64'd3;
    step();
    check("R5 smaller write keeps irq", {63'd0, timer_irq_o}, 64'd1);
    repeat (3) step();
    check("R5 irq held without write", {63'd0, timer_irq_o}, 64'd1);
    cmp_we = 1'b1; cmp_wdata = m_cnt + 64'd1;
    step();
    check("R3 compare one above count clears", {63'd0, timer_irq_o}, 64'd0);
    step();
    check("R3 equality raises next edge", {63'd0, timer_irq_o}, 64'd1);
  endtask

  task automatic test_large_compare();
    cmp_we = 1'b1; cmp_wdata = 64'hFFFF_FFFF_FFFF_FFF0;
    step();
    check("R3 same-edge write uses new value", {63'd0, timer_irq_o}, 64'd0);
    repeat (4) step();
    check("R3 stays low below compare", {63'd0, timer_irq_o}, 64'd0);
  endtask

  task automatic test_soft();
    sw_we = 1'b1; sw_wdata = 1'b1;
    step();
    check("R6 soft set", {63'd0, soft_irq_o}, 64'd1);
    sw_wdata = 1'b0;
    repeat (3) step();
    check("R6 soft holds without strobe", {63'd0, soft_irq_o}, 64'd1);
    sw_we = 1'b1; sw_wdata = 1'b1;
    step();
    check("R6 soft rewrite 1", {63'd0, soft_irq_o}, 64'd1);
    sw_we = 1'b1; sw_wdata = 1'b0;
    step();
    check("R6 soft cleared", {63'd0, soft_irq_o}, 64'd0);
    sw_wdata = 1'b1;
    step();
    check("R6 soft stays clear", {63'd0, soft_irq_o}, 64'd0);
  endtask

  task automatic test_wrap();
    cmp8_we = 1'b1; cmp8_wdata = 8'd200;
    step();
    while (m_cnt[7:0] != 8'd255) step();
    check("R8 narrow irq before wrap", {63'd0, irq8}, 64'd1);
    step();
    check("R8 narrow count wrapped to zero", {56'd0, count8}, 64'd0);
    step();
    check("R8 narrow irq drops after wrap", {63'd0, irq8}, 64'd0);
  endtask

  task automatic test_midrun_reset();
    sw_we = 1'b1; sw_wdata = 1'b1;
    step();
    rst = 1'b1;
    cmp_we = 1'b1; cmp_wdata = 64'd1000;
    step();
    check("R7 count cleared mid-run", count_o, 64'd0);
    check("R7 soft cleared mid-run", {63'd0, soft_irq_o}, 64'd0);
    check("R7 timer_irq cleared mid-run", {63'd0, timer_irq_o}, 64'd0);
    rst = 1'b0;
    step();
    check("R4 compare back to zero after reset", {63'd0, timer_irq_o}, 64'd1);
  endtask

  initial begin
    @(negedge clk);
    test_reset();
    test_first_irq();
    test_future_compare();
    test_not_larger();
    test_large_compare();
    test_soft();
    test_wrap();
    test_midrun_reset();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule